// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port with Pulldown Control

This block is a six-pin bidirectional I/O port seen by a processor as four byte-wide registers. A data latch holds the values the port drives, a direction register picks input or output for each pin, and a write-only inhibit register switches off the weak pulldown of each pin. A fourth location holds one write-only bit. That bit switches the pulldowns of the lower four pins of a neighbouring port together. The neighbouring port supplies its direction bits on `aux_dir`.

Each pin gets an output enable, an output value and a pulldown enable. Pin input levels pass through a two-flop synchronizer before any read uses them. A read of the data location returns the latch value for output pins and the synchronized pin level for input pins. The `sw_pd_off` input is a global software option. When it is high, every pulldown the block controls is off.

Register map (`bus_addr`): 0 = data latch, 1 = direction, 2 = pulldown inhibit, 3 = neighbouring-port pulldown bit (bit 0).

Top module: `gpio_pd_port`

## Requirements
- R1: While `rst_n` is low at a rising edge, the data latch, the direction register, all six inhibit bits and the neighbouring-port bit are cleared. After reset every `pin_oe` bit is 0 and every `pin_out` bit is 0.
- R2: A write to address 0 loads `bus_wdata[5:0]` into the data latch at the next rising edge, whatever the direction bits hold. `pin_out` shows the latch.
- R3: Address 1 can be written and read back. A 1 in direction bit i makes pin i an output, so `pin_oe[i]` equals direction bit i.
- R4: Reading address 0 returns the latch value in each bit whose direction bit is 1.
- R5: Reading address 0 returns the pin level in each bit whose direction bit is 0. That level is sampled through two flops, so a change on `pin_in` first shows on a read after the second rising edge.
- R6: Addresses 2 and 3 are write-only and always read as 0x00.
- R7: `pin_pd_en[i]` is 1 only when direction bit i is 0, inhibit bit i (address 2, bit i) is 0 and `sw_pd_off` is 0. An inhibit bit of 1 turns that pulldown off.
- R8: While `sw_pd_off` is 1, every bit of `pin_pd_en` and `aux_pd_en` is 0.
- R9: Bit 0 of address 3 controls all four `aux_pd_en` bits together. `aux_pd_en[j]` is 1 only when that bit is 0, `aux_dir[j]` is 0 and `sw_pd_off` is 0.
- R10: Read bits 7:6 of addresses 0 and 1 are always 0. `bus_rdata` is 0x00 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, sampled at rising edge |
| bus_rd | input | 1 | Read strobe, read data is combinational |
| bus_rdata | output | 8 | Read data |
| sw_pd_off | input | 1 | Global pulldown disable option |
| aux_dir | input | 4 | Direction bits of neighbouring port's lower pins (1 = output) |
| pin_in | input | 6 | Pad input levels |
| pin_out | output | 6 | Pad output values |
| pin_oe | output | 6 | Pad output enables |
| pin_pd_en | output | 6 | Pad pulldown enables |
| aux_pd_en | output | 4 | Pulldown enables for neighbouring port's lower four pins |

## Verification
Random mixes of direction bits are run against random latch contents and random pin levels. Because the latch and the pins usually disagree, each bit of a data read shows whether it came from the latch or from the pin. Inhibit patterns, `aux_dir` values and the global option are drawn at random. The pulldown outputs are compared against an equation with all three terms, so a term that is dropped or inverted shows up. Directed cases cover the two-edge synchronizer delay, a latch write while all pins are inputs (seen later by turning them into outputs), and the write-only reads.

// File: rtl/gpio_pd_pkg.sv
// Package: shared register selects for the GPIO port with pulldown control.
// Assumes a two-bit register address on a byte-wide processor bus.
package gpio_pd_pkg;
    localparam int unsigned REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        REG_LATCH = 2'd0,
        REG_DIR   = 2'd1,
        REG_PDINH = 2'd2,
        REG_AUXPD = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_pd_sync.sv
// Multi-flop synchronizer for the pad input levels.
// Assumes STAGES >= 2. Output lags input by STAGES rising edges. Reset clears all stages.
module gpio_pd_sync #(
    parameter int unsigned W      = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    // Shift the sampled levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
        end else begin
            stg_q[0] <= din;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
    end

    assign dout = stg_q[STAGES-1];

    // R5: the last stage holds what the stage before it held one edge earlier
    p_sync_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stg_q[STAGES-1] == $past(stg_q[STAGES-2])));
endmodule

// File: rtl/gpio_pd_regs.sv
// Register file: data latch, direction, pin pulldown inhibits, neighbouring-port bit.
// Assumes writes take effect at the next rising edge. Synchronous active-low reset clears all.
module gpio_pd_regs
    import gpio_pd_pkg::*;
#(
    parameter int unsigned NPINS = 6,
    parameter int unsigned DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              wr,
    output logic [NPINS-1:0]  latch_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  pdinh_q,
    output logic              auxinh_q
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    // Load the addressed register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q  <= '0;
            dir_q    <= '0;
            pdinh_q  <= '0;
            auxinh_q <= 1'b0;
        end else if (wr) begin
            case (sel)
                REG_LATCH: latch_q  <= wdata[NPINS-1:0];
                REG_DIR:   dir_q    <= wdata[NPINS-1:0];
                REG_PDINH: pdinh_q  <= wdata[NPINS-1:0];
                REG_AUXPD: auxinh_q <= wdata[0];
                default:   ;
            endcase
        end
    end

    // R1: the edge after reset leaves every register cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (latch_q == '0 && dir_q == '0 && pdinh_q == '0 && !auxinh_q));

    // R2: a latch write lands whatever the direction bits hold
    p_latch_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == REG_LATCH) |=> (latch_q == $past(wdata[NPINS-1:0])));

    // R3: a direction write lands at the next edge
    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == REG_DIR) |=> (dir_q == $past(wdata[NPINS-1:0])));
endmodule

// File: rtl/gpio_pd_pull.sv
// Pulldown enable logic for the port pins and the neighbouring port's lower pins.
// Assumes a direction bit of 1 means output. A pulldown is on only for an input
// whose inhibit is clear while the global option is clear.
module gpio_pd_pull #(
    parameter int unsigned NPINS = 6,
    parameter int unsigned NAUX  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] pdinh,
    input  logic             auxinh,
    input  logic [NAUX-1:0]  aux_dir,
    input  logic             sw_off,
    output logic [NPINS-1:0] pd_en,
    output logic [NAUX-1:0]  aux_pd_en
);
    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_pin
            // One pin: pulldown on for an uninhibited input.
            always_comb pd_en[i] = !dir[i] && !pdinh[i] && !sw_off;
        end
        for (i = 0; i < NAUX; i++) begin : g_aux
            // One neighbouring pin: the shared bit gates all four together.
            always_comb aux_pd_en[i] = !aux_dir[i] && !auxinh && !sw_off;
        end
    endgenerate

    // R8: the global option switches every pulldown off
    p_global_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_off |-> (pd_en == '0 && aux_pd_en == '0));

    // R7: a pin set as output never has its pulldown on
    p_no_pd_on_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_en & dir) == '0);

    // R9: a set shared bit holds all four neighbouring pulldowns off
    p_aux_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        auxinh |-> (aux_pd_en == '0));
endmodule

// File: rtl/gpio_pd_rdmux.sv
// Read-data selector. Data reads take the latch for output bits and the
// synchronized pin for input bits. Write-only locations and idle reads give 0.
module gpio_pd_rdmux
    import gpio_pd_pkg::*;
#(
    parameter int unsigned NPINS = 6,
    parameter int unsigned DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] addr,
    input  logic              rd,
    input  logic [NPINS-1:0]  latch,
    input  logic [NPINS-1:0]  dir,
    input  logic [NPINS-1:0]  pin_sync,
    output logic [DW-1:0]     rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    // Choose the returned byte from the addressed location.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                REG_LATCH: rdata[NPINS-1:0] = (dir & latch) | (~dir & pin_sync);
                REG_DIR:   rdata[NPINS-1:0] = dir;
                default:   rdata = '0;
            endcase
        end
    end

    // R6: write-only locations read as zero
    p_wo_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (sel == REG_PDINH || sel == REG_AUXPD)) |-> (rdata == '0));

    // R10: no read strobe means a zero bus
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (rdata == '0));
endmodule

// File: rtl/gpio_pd_port.sv
// Top: six-pin bidirectional GPIO port with register access and pulldown control.
// Assumes split pad signals (in, out, output enable, pulldown enable) and a
// byte-wide bus with combinational read data. Synchronous active-low reset.
module gpio_pd_port
    import gpio_pd_pkg::*;
#(
    parameter int unsigned NPINS       = 6,
    parameter int unsigned NAUX        = 4,
    parameter int unsigned DW          = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    input  logic              sw_pd_off,
    input  logic [NAUX-1:0]   aux_dir,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_pd_en,
    output logic [NAUX-1:0]   aux_pd_en
);
    logic [NPINS-1:0] latch_q, dir_q, pdinh_q, pin_sync;
    logic             auxinh_q;

    gpio_pd_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
        .latch_q(latch_q), .dir_q(dir_q), .pdinh_q(pdinh_q), .auxinh_q(auxinh_q)
    );

    gpio_pd_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_sync)
    );

    gpio_pd_pull #(.NPINS(NPINS), .NAUX(NAUX)) u_pull (
        .clk(clk), .rst_n(rst_n), .dir(dir_q), .pdinh(pdinh_q), .auxinh(auxinh_q),
        .aux_dir(aux_dir), .sw_off(sw_pd_off), .pd_en(pin_pd_en), .aux_pd_en(aux_pd_en)
    );

    gpio_pd_rdmux #(.NPINS(NPINS), .DW(DW)) u_rdmux (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .latch(latch_q),
        .dir(dir_q), .pin_sync(pin_sync), .rdata(bus_rdata)
    );

    assign pin_out = latch_q;
    assign pin_oe  = dir_q;

    // R4: an output bit of a data read always matches the driven value
    p_out_reads_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_LATCH) |-> ((bus_rdata[NPINS-1:0] & pin_oe) == (pin_out & pin_oe)));

    // R10: bits above the pins never read as 1
    p_hi_bits_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DW-1:NPINS] == '0);
endmodule

// File: tb/gpio_pd_port_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random traffic.
module gpio_pd_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       sw_pd_off = 1'b0;
    logic [3:0] aux_dir = '0;
    logic [5:0] pin_in = '0;
    logic [5:0] pin_out, pin_oe, pin_pd_en;
    logic [3:0] aux_pd_en;

    int checks = 0, failures = 0;
    logic [5:0] m_latch = '0, m_dir = '0, m_inh = '0;
    logic       m_aux = 1'b0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    gpio_pd_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .sw_pd_off(sw_pd_off),
        .aux_dir(aux_dir), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pd_en(pin_pd_en), .aux_pd_en(aux_pd_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_pd(logic [5:0] d, logic [5:0] inh, logic off);
        return off ? 6'h0 : (~d & ~inh);
    endfunction

    function automatic logic [3:0] exp_aux(logic [3:0] ad, logic inh, logic off);
        return (off || inh) ? 4'h0 : ~ad;
    endfunction

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            2'd0: m_latch = d[5:0];
            2'd1: m_dir = d[5:0];
            2'd2: m_inh = d[5:0];
            default: m_aux = d[0];
        endcase
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic set_pins(input logic [5:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (2) @(posedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [7:0] d;
        rd_reg(2'd0, d);
        check({"R4 R5 ", tag}, d, {2'b00, (m_dir & m_latch) | (~m_dir & pin_in)});
        rd_reg(2'd1, d);
        check({"R3 ", tag}, d, {2'b00, m_dir});
        rd_reg(2'd2, d);
        check({"R6 ", tag}, d, 8'h00);
        rd_reg(2'd3, d);
        check({"R6 ", tag}, d, 8'h00);
        check({"R2 ", tag}, pin_out, m_latch);
        check({"R3 ", tag}, pin_oe, m_dir);
        check({"R7 R8 ", tag}, pin_pd_en, exp_pd(m_dir, m_inh, sw_pd_off));
        check({"R9 R8 ", tag}, aux_pd_en, exp_aux(aux_dir, m_aux, sw_pd_off));
    endtask

    initial begin : watchdog
        #(8 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd5117));
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check("R1 oe", pin_oe, 6'h00);
        check("R1 out", pin_out, 6'h00);
        check("R1 pd", pin_pd_en, 6'h3F);
        check("R1 aux", aux_pd_en, 4'hF);
        rd_reg(2'd1, rv);
        check("R1 dir read", rv, 8'h00);

        // R2: latch write while all pins are inputs, then seen once outputs
        wr_reg(2'd0, 8'hE5);
        check("R2 out while input", pin_out, 6'h25);
        wr_reg(2'd1, 8'hFF);
        rd_reg(2'd0, rv);
        check("R4 R10 all outputs", rv, 8'h25);
        rd_reg(2'd1, rv);
        check("R3 R10 dir read", rv, 8'h3F);

        // R5: two-edge synchronizer delay on an input pin
        wr_reg(2'd1, 8'h00);
        set_pins(6'h00);
        @(negedge clk) pin_in = 6'h2A;
        @(posedge clk);
        rd_reg(2'd0, rv);
        check("R5 one edge old", rv, 8'h00);
        @(posedge clk);
        rd_reg(2'd0, rv);
        check("R5 two edges new", rv, 8'h2A);

        // R10: idle bus reads zero
        #1 check("R10 idle", bus_rdata, 8'h00);

        // R7 / R9 / R8 directed
        wr_reg(2'd2, 8'h0F);
        check("R7 inhibit", pin_pd_en, 6'h30);
        wr_reg(2'd3, 8'h01);
        check("R9 shared off", aux_pd_en, 4'h0);
        wr_reg(2'd3, 8'h00);
        aux_dir = 4'h5;
        #1 check("R9 aux dir", aux_pd_en, 4'hA);
        sw_pd_off = 1'b1;
        #1 check("R8 pin", pin_pd_en, 6'h00);
        check("R8 aux", aux_pd_en, 4'h0);
        sw_pd_off = 1'b0;

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            int op = $urandom_range(0, 5);
            case (op)
                0, 1: wr_reg(2'($urandom_range(0, 3)), 8'($urandom));
                2: set_pins(6'($urandom));
                3: begin @(negedge clk); aux_dir = 4'($urandom); end
                4: begin @(negedge clk); sw_pd_off = ($urandom_range(0, 3) == 0); end
                default: wr_reg(2'd1, 8'($urandom));
            endcase
            set_pins(pin_in);
            check_all("random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule